// File: doc/BRIEF.md
# Nested Priority Event Controller

This block sits beside a processor core and decides which of sixteen prioritized event levels the core should service next. Level 0 outranks every other level and level 15 ranks lowest. The fixed order is: debug/emulation, reset, non-maskable interrupt, exception, an unused reserved slot, hardware error, core timer, and then nine general-purpose levels (7 to 15). Incoming requests are captured into a pending register. A mask register and a global enable then decide which of the captured requests may be serviced. Among those, the lowest-numbered one is offered to the core.

An offer is made only if the candidate outranks every level that is already running. The running levels are held in an active register that records nesting. When the core takes an offered event, its pending bit is dropped and its active bit is raised in the same cycle. A return strobe from the core retires the innermost running level. This hands control back to the level it had preempted, and it lets the next waiting event compete on the following cycle.

Software reaches the three registers through a small read/write port. A supervisor qualifier on that port guards the mask register and the active register. A pair of strobes switches the general-purpose levels on and off as a group.

Top module: `evt_nest_ctrl`

## Requirements
- R1: After reset the pending and active registers read 0x0000, the mask register reads 0x0007, the global enable is on, and `issue_vld` is 0.
- R2: A level whose `evt_req` bit is 1 at a rising clock edge has its pending bit set from the next cycle on. Level 4 never latches, and bit 4 of the pending and active registers always reads 0.
- R3: A write with `reg_sel`=1 (mask) takes effect only when `supv`=1. Bits 0 to 2 always read 1 and bit 4 always reads 0. Mask and active reads return 0 when `supv`=0. `reg_sel`=3 reads 0.
- R4: A pending level can be offered only when its mask bit is 1. Levels 7 to 15 also need the global enable to be on. Levels 0 to 2 are never blocked.
- R5: `issue_lvl` names the lowest-numbered level that meets R4.
- R6: `issue_vld` is 1 only when that level is strictly lower than the lowest-numbered set active bit, or when no active bit is set.
- R7: When `issue_vld` and `core_ack` are both 1 at an edge, the offered level's pending bit clears and its active bit sets on that edge. A request for the same level on the same edge keeps the pending bit set.
- R8: `core_ret` clears the lowest-numbered set active bit. When no active bit is set, it has no effect. When it coincides with an accept, the accepted bit is set after the retirement.
- R9: A write with `reg_sel`=0 replaces only those pending bits whose mask bit is 0. It needs no supervisor qualifier.
- R10: `gen_on` turns the global enable on and `gen_off` turns it off. When both are 1 in one cycle, the enable ends up off.
- R11: Writes with `reg_sel`=2 (active) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_req | input | 16 | Event request per level, bit n = level n |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 pending, 1 mask, 2 active, 3 none |
| reg_wdata | input | 16 | Write data |
| supv | input | 1 | Supervisor-mode qualifier for the access |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| gen_on | input | 1 | Global enable set strobe for levels 7 to 15 |
| gen_off | input | 1 | Global enable clear strobe for levels 7 to 15 |
| issue_vld | output | 1 | An event is offered to the core |
| issue_lvl | output | 4 | Level of the offered event |
| core_ack | input | 1 | Core accepts the offered event |
| core_ret | input | 1 | Core returns from its innermost event |

## Verification
Two things can happen on the same edge: the core accepts a new event, and the core returns from the innermost running one. The active register then loses its lowest bit and gains a still lower one in a single update. A directed step provokes this by acknowledging level 3 while level 6 is running and returning at the same time. A long random phase also drives `core_ack` and `core_ret` independently, so the two collide many times over arbitrary nesting depths. In every cycle, a behavioural model in the bench predicts the active and pending contents and the offered level. The bench judges the result by comparing that prediction against register reads and the issue outputs.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int unsigned EVT_LEVELS  = 16;
    localparam int unsigned EVT_GP_BASE = 7;
    localparam int unsigned EVT_RSV_LVL = 4;
    localparam int unsigned EVT_FIXED_N = 3;

    typedef enum logic [1:0] {
        SEL_LATCH  = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_ACTIVE = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
    parameter int N = 16,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    // lowest set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/evt_arb.sv
module evt_arb #(
    parameter int N       = 16,
    parameter int W       = $clog2(N),
    parameter int GP_BASE = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] latch_q,
    input  logic [N-1:0] mask_q,
    input  logic [N-1:0] active_q,
    input  logic         gen_en_q,
    output logic         issue_vld,
    output logic [W-1:0] issue_lvl
);
    logic [N-1:0] elig;
    logic         cand_found;
    logic [W-1:0] cand_idx;
    logic         act_found;
    logic [W-1:0] act_idx;

    for (genvar g = 0; g < N; g++) begin : g_elig
        if (g < GP_BASE) begin : g_core
            assign elig[g] = latch_q[g] & mask_q[g];
        end else begin : g_gp
            assign elig[g] = latch_q[g] & mask_q[g] & gen_en_q;
        end
    end

    evt_prio_enc #(.N(N), .W(W)) u_cand (
        .vec  (elig),
        .found(cand_found),
        .idx  (cand_idx)
    );

    evt_prio_enc #(.N(N), .W(W)) u_act (
        .vec  (active_q),
        .found(act_found),
        .idx  (act_idx)
    );

    always_comb begin
        issue_lvl = cand_idx;
        issue_vld = cand_found && (!act_found || (cand_idx < act_idx));
    end

    // R4: an offered level is pending and unmasked
    assert_offer_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |-> (latch_q[issue_lvl] && mask_q[issue_lvl]));

    // R6: no offered level is already running, nor any level above it
    assert_offer_outranks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |-> ((active_q & N'((32'd1 << (32'(issue_lvl) + 32'd1)) - 32'd1)) == '0));
endmodule

// File: rtl/evt_state.sv
module evt_state
    import evt_pkg::*;
#(
    parameter int N       = 16,
    parameter int W       = $clog2(N),
    parameter int RSV_LVL = 4,
    parameter int FIXED_N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_req,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [N-1:0] wdata,
    input  logic         supv,
    input  logic         en_set,
    input  logic         en_clr,
    input  logic         acc,
    input  logic [W-1:0] acc_lvl,
    input  logic         ret,
    output logic [N-1:0] latch_q,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] active_q,
    output logic         gen_en_q
);
    localparam logic [N-1:0] FIX_MASK = N'((32'd1 << FIXED_N) - 32'd1);
    localparam logic [N-1:0] RSV_MASK = N'(32'd1 << RSV_LVL);

    typedef struct packed {
        logic [N-1:0] lat;
        logic [N-1:0] msk;
        logic [N-1:0] act;
        logic         en;
    } st_t;

    st_t          s_d, s_q;
    logic         in_found;
    logic [W-1:0] in_idx;

    evt_prio_enc #(.N(N), .W(W)) u_inner (
        .vec  (s_q.act),
        .found(in_found),
        .idx  (in_idx)
    );

    always_comb begin
        s_d = s_q;
        // pending register: accept clear, software write, new capture
        if (acc) s_d.lat[acc_lvl] = 1'b0;
        if (wr_en && sel == SEL_LATCH)
            s_d.lat = (s_d.lat & s_q.msk) | (wdata & ~s_q.msk);
        s_d.lat = (s_d.lat | evt_req) & ~RSV_MASK;
        // mask register
        if (wr_en && supv && sel == SEL_MASK)
            s_d.msk = (wdata | FIX_MASK) & ~RSV_MASK;
        // nesting register: retire first, then enter
        if (ret && in_found) s_d.act[in_idx] = 1'b0;
        if (acc) s_d.act[acc_lvl] = 1'b1;
        s_d.act = s_d.act & ~RSV_MASK;
        // global enable, clear wins
        if (en_set) s_d.en = 1'b1;
        if (en_clr) s_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.lat <= '0;
            s_q.msk <= FIX_MASK;
            s_q.act <= '0;
            s_q.en  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign latch_q  = s_q.lat;
    assign mask_q   = s_q.msk;
    assign active_q = s_q.act;
    assign gen_en_q = s_q.en;

    assert_rsv_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.lat[RSV_LVL] && !s_q.act[RSV_LVL]);

    assert_fixed_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        &s_q.msk[FIXED_N-1:0]);

    assert_mask_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !supv && sel == SEL_MASK) |=> $stable(s_q.msk));

    assert_accept_enters_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> s_q.act[$past(acc_lvl)]);

    assert_return_retires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !acc && (s_q.act != '0)) |=>
            ($countones(s_q.act) + 1 == $countones($past(s_q.act))));

    assert_active_readonly_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_ACTIVE && !acc && !ret) |=> $stable(s_q.act));

    assert_enable_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !s_q.en);
endmodule

// File: rtl/evt_nest_ctrl.sv
module evt_nest_ctrl
    import evt_pkg::*;
#(
    parameter int N       = EVT_LEVELS,
    parameter int GP_BASE = EVT_GP_BASE,
    parameter int RSV_LVL = EVT_RSV_LVL,
    parameter int FIXED_N = EVT_FIXED_N,
    localparam int W      = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_req,
    input  logic         reg_wr,
    input  logic [1:0]   reg_sel,
    input  logic [N-1:0] reg_wdata,
    input  logic         supv,
    output logic [N-1:0] reg_rdata,
    input  logic         gen_on,
    input  logic         gen_off,
    output logic         issue_vld,
    output logic [W-1:0] issue_lvl,
    input  logic         core_ack,
    input  logic         core_ret
);
    reg_sel_e     sel;
    logic [N-1:0] latch_q, mask_q, active_q;
    logic         gen_en_q;
    logic         acc;

    assign sel = reg_sel_e'(reg_sel);
    assign acc = issue_vld & core_ack;

    evt_state #(.N(N), .W(W), .RSV_LVL(RSV_LVL), .FIXED_N(FIXED_N)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_req (evt_req),
        .wr_en   (reg_wr),
        .sel     (sel),
        .wdata   (reg_wdata),
        .supv    (supv),
        .en_set  (gen_on),
        .en_clr  (gen_off),
        .acc     (acc),
        .acc_lvl (issue_lvl),
        .ret     (core_ret),
        .latch_q (latch_q),
        .mask_q  (mask_q),
        .active_q(active_q),
        .gen_en_q(gen_en_q)
    );

    evt_arb #(.N(N), .W(W), .GP_BASE(GP_BASE)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_q  (latch_q),
        .mask_q   (mask_q),
        .active_q (active_q),
        .gen_en_q (gen_en_q),
        .issue_vld(issue_vld),
        .issue_lvl(issue_lvl)
    );

    always_comb begin
        unique case (sel)
            SEL_LATCH:  reg_rdata = latch_q;
            SEL_MASK:   reg_rdata = supv ? mask_q : '0;
            SEL_ACTIVE: reg_rdata = supv ? active_q : '0;
            default:    reg_rdata = '0;
        endcase
    end

    // R1: nothing is offered in the first cycle out of reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !issue_vld);
endmodule

// File: tb/sim_evt_nest_ctrl.sv
`timescale 1ns/1ps
module sim_evt_nest_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_req = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic        supv = 1'b1;
    logic [15:0] reg_rdata;
    logic        gen_on = 1'b0, gen_off = 1'b0;
    logic        issue_vld;
    logic [3:0]  issue_lvl;
    logic        core_ack = 1'b0, core_ret = 1'b0;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [15:0] m_lat, m_msk, m_act;
    logic        m_en;

    always #10 clk = ~clk;

    evt_nest_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .supv(supv),
        .reg_rdata(reg_rdata), .gen_on(gen_on), .gen_off(gen_off),
        .issue_vld(issue_vld), .issue_lvl(issue_lvl),
        .core_ack(core_ack), .core_ret(core_ret)
    );

    function automatic void mdl_offer(output logic v, output int lvl);
        int inner;
        inner = 16;
        v = 1'b0;
        lvl = 0;
        for (int i = 15; i >= 0; i--) if (m_act[i]) inner = i;
        for (int i = 15; i >= 0; i--)
            if (m_lat[i] && m_msk[i] && (i < 7 || m_en)) lvl = i;
        for (int i = 0; i < 16; i++)
            if (m_lat[i] && m_msk[i] && (i < 7 || m_en)) v = 1'b1;
        if (lvl >= inner) v = 1'b0;
    endfunction

    function automatic logic [15:0] mdl_read();
        case (reg_sel)
            2'd0: return m_lat;
            2'd1: return supv ? m_msk : 16'h0;
            2'd2: return supv ? m_act : 16'h0;
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare, then advance one clock and update the model
    task automatic cyc(input string tag);
        logic ev;
        int   el;
        logic [15:0] er;
        int   inner;
        #2;
        mdl_offer(ev, el);
        er = mdl_read();
        chk({tag, " issue_vld"}, issue_vld == ev, {31'd0, issue_vld}, {31'd0, ev});
        if (ev) chk({tag, " issue_lvl"}, issue_lvl == 4'(el), {28'd0, issue_lvl}, el);
        chk({tag, " rdata"}, reg_rdata == er, {16'd0, reg_rdata}, {16'd0, er});
        @(posedge clk);
        inner = 16;
        for (int i = 15; i >= 0; i--) if (m_act[i]) inner = i;
        if (ev && core_ack) m_lat[el] = 1'b0;
        if (reg_wr && reg_sel == 2'd0)
            for (int i = 0; i < 16; i++) if (!m_msk[i]) m_lat[i] = reg_wdata[i];
        m_lat = m_lat | evt_req;
        m_lat[4] = 1'b0;
        if (reg_wr && supv && reg_sel == 2'd1) begin
            m_msk = reg_wdata;
            m_msk[2:0] = 3'b111;
            m_msk[4] = 1'b0;
        end
        if (core_ret && inner < 16) m_act[inner] = 1'b0;
        if (ev && core_ack) m_act[el] = 1'b1;
        if (gen_on) m_en = 1'b1;
        if (gen_off) m_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle();
        evt_req = '0; reg_wr = 0; core_ack = 0; core_ret = 0; gen_on = 0; gen_off = 0;
    endtask

    task automatic rd(input logic [1:0] s, input logic sv, input logic [15:0] exp, input string tag);
        idle(); reg_sel = s; supv = sv;
        #2 chk(tag, reg_rdata == exp, {16'd0, reg_rdata}, {16'd0, exp});
        cyc(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        m_lat = '0; m_msk = 16'h0007; m_act = '0; m_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, 1, 16'h0000, "R1 pending");
        rd(2'd1, 1, 16'h0007, "R1 mask");
        rd(2'd2, 1, 16'h0000, "R1 active");
        chk("R1 no offer", issue_vld == 1'b0, {31'd0, issue_vld}, 0);
        // R2 capture, level 4 ignored
        idle(); evt_req = 16'h0210; cyc("R2");
        rd(2'd0, 1, 16'h0200, "R2 pending");
        chk("R4 masked level waits", issue_vld == 1'b0, {31'd0, issue_vld}, 0);
        // R3 mask protection
        idle(); reg_wr = 1; reg_sel = 2'd1; reg_wdata = 16'hFFFF; supv = 0; cyc("R3");
        rd(2'd1, 1, 16'h0007, "R3 unprivileged write");
        rd(2'd1, 0, 16'h0000, "R3 unprivileged read");
        rd(2'd3, 1, 16'h0000, "R3 none select");
        idle(); reg_wr = 1; reg_sel = 2'd1; reg_wdata = 16'hFFFF; supv = 1; cyc("R3");
        rd(2'd1, 1, 16'hFFEF, "R3 mask full");
        // R5 priority
        chk("R5 level 9 offered", issue_vld && issue_lvl == 4'd9, {27'd0, issue_vld, issue_lvl}, 32'h19);
        idle(); evt_req = 16'h1040; cyc("R5");
        #2 chk("R5 level 6 wins", issue_vld && issue_lvl == 4'd6, {27'd0, issue_vld, issue_lvl}, 32'h16);
        // R7 accept
        idle(); core_ack = 1; cyc("R7");
        rd(2'd2, 1, 16'h0040, "R7 active");
        rd(2'd0, 1, 16'h1200, "R7 pending");
        // R6 nesting
        chk("R6 lower level held", issue_vld == 1'b0, {31'd0, issue_vld}, 0);
        idle(); evt_req = 16'h0008; cyc("R6");
        #2 chk("R6 level 3 preempts", issue_vld && issue_lvl == 4'd3, {27'd0, issue_vld, issue_lvl}, 32'h13);
        // R8 accept and return together
        idle(); core_ack = 1; core_ret = 1; cyc("R8");
        rd(2'd2, 1, 16'h0008, "R8 accept with return");
        idle(); core_ret = 1; cyc("R8");
        rd(2'd2, 1, 16'h0000, "R8 retire");
        idle(); core_ret = 1; cyc("R8 empty return");
        rd(2'd2, 1, 16'h0000, "R8 empty return");
        // R10 global enable
        idle(); gen_off = 1; cyc("R10");
        #2 chk("R10 off blocks", issue_vld == 1'b0, {31'd0, issue_vld}, 0);
        idle(); gen_on = 1; gen_off = 1; cyc("R10");
        #2 chk("R10 both -> off", issue_vld == 1'b0, {31'd0, issue_vld}, 0);
        idle(); gen_on = 1; cyc("R10");
        #2 chk("R10 on", issue_vld && issue_lvl == 4'd9, {27'd0, issue_vld, issue_lvl}, 32'h19);
        // R9 pending write only on masked bits
        idle(); reg_wr = 1; reg_sel = 2'd1; reg_wdata = 16'hFDFF; cyc("R9");
        idle(); reg_wr = 1; reg_sel = 2'd0; reg_wdata = 16'h0400; cyc("R9");
        rd(2'd0, 1, 16'h1000, "R9 pending write");
        // R11 active read-only
        idle(); reg_wr = 1; reg_sel = 2'd2; reg_wdata = 16'hFFFF; cyc("R11");
        rd(2'd2, 1, 16'h0000, "R11 active write ignored");
        // R7 same-level request on accept edge
        idle(); core_ack = 1; evt_req = 16'h1000; cyc("R7");
        rd(2'd0, 1, 16'h1000, "R7 re-request kept");
        idle(); core_ret = 1; cyc("R8");
        // random phase against the model
        for (int n = 0; n < 5000; n++) begin
            evt_req   = 16'($urandom & $urandom & $urandom & $urandom);
            core_ack  = 1'($urandom % 2);
            core_ret  = ($urandom % 4) == 0;
            reg_wr    = ($urandom % 8) == 0;
            reg_sel   = 2'($urandom);
            reg_wdata = 16'($urandom);
            supv      = ($urandom % 4) != 0;
            gen_on    = ($urandom % 16) == 0;
            gen_off   = ($urandom % 24) == 0;
            cyc("R6 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule